// File: doc/BRIEF.md
# Multi-Pattern Pipelined String Matcher

This block scans a packet payload, presented as a stream of words of `LANES` bytes, against a fixed set of byte patterns chosen at elaboration time. Each byte is turned into 256 one-hot character lines by a shared decoder. Every pattern owns a short chain of match stages. A stage is true when the stage before it was true one byte earlier and its own character line is set. Partial-match state therefore moves forward with the data. No byte is stored or scanned a second time, and a match that crosses a word boundary is carried in one register per stage.

Each pattern may contain single-byte wildcard positions and may be anchored to the first payload byte. For each packet the block produces one sticky bit per pattern. The result is published with a one-cycle `match_valid` pulse in the cycle after the end-of-packet word. The bits then hold until the next packet starts.

A small controller tracks framing with three states. `S_IDLE` waits for a start word. `S_BODY` is inside a packet. `S_REPORT` is the single cycle that presents the result. The transitions are as follows:
- `S_IDLE` goes to `S_BODY` on a start word without end, and to `S_REPORT` on a start word with end.
- `S_BODY` goes to `S_REPORT` on a valid end word.
- `S_REPORT` goes to `S_BODY` or `S_REPORT` on a new start word, and to `S_IDLE` otherwise.

Top module: `pattern_scan`

## Requirements
- R1: After reset `match_valid` is 0 and every bit of `match_bits` is 0.
- R2: An unanchored pattern is found at any byte offset, including one that straddles two or more words. Lane 0 (`in_data[7:0]`) carries the earliest byte of a word.
- R3: A pattern lying wholly inside one word is found at every lane position, and several hits of one pattern in a packet set its bit once.
- R4: A wildcard position in a pattern accepts any byte value.
- R5: An anchored pattern is reported only when it begins at the first payload byte, which is lane 0 of the start word.
- R6: The match bits of a packet appear together with a one-cycle `match_valid` pulse in the cycle after the accepted end-of-packet word. They stay unchanged until the next accepted start word.
- R7: A start word clears all partial-match state and all match bits. A prefix seen in an earlier or aborted packet never completes a match in a later one, and a start word in the middle of a packet begins a new packet.
- R8: In the end word, only lanes whose `in_keep` bit is 1 take part. `in_keep` is contiguous from lane 0, and a pattern that would complete only in a masked lane is not reported.
- R9: Words with `in_valid` low, and valid words without `in_sop` outside a packet, change neither `match_bits` nor `match_valid`.
- R10: All patterns are evaluated in parallel on the same bytes, and each sets its own bit (bit p for pattern p).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_data | input | LANES*8 | Payload bytes, lane 0 in bits [7:0] |
| in_keep | input | LANES | Per-lane byte-valid mask, contiguous from lane 0 |
| match_valid | output | 1 | One-cycle pulse marking the packet result |
| match_bits | output | NPAT | Sticky per-pattern match flags |

## Verification
The bench builds the block with four lanes and its default pattern set. That set holds two unanchored three-byte strings, one three-byte string with a wildcard in the middle, and one anchored four-byte string. With these lengths against four lanes, a pattern can end in every lane and can straddle a word boundary at every split point. An end word with one to three kept lanes lets a pattern try to finish in masked bytes. Random packets drawn from a small alphabet produce dense overlapping hits, and directed cases reach the anchoring, restart and ignored-word behaviour.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    localparam int unsigned DEF_NPAT   = 4;
    localparam int unsigned DEF_MAXLEN = 4;
    localparam int unsigned DEF_LEN_W  = 4;

    // pattern p, position k lives at bits [(p*MAXLEN+k)*8 +: 8]
    localparam logic [DEF_NPAT*DEF_MAXLEN*8-1:0] DEF_CHARS = {
        8'h44, 8'h41, 8'h45, 8'h48,   // p3: H E A D
        8'h00, 8'h7a, 8'h00, 8'h78,   // p2: x ? z
        8'h00, 8'h63, 8'h63, 8'h64,   // p1: d c c
        8'h00, 8'h63, 8'h62, 8'h61    // p0: a b c
    };
    localparam logic [DEF_NPAT*DEF_MAXLEN-1:0] DEF_WILD   = 16'h0200;
    localparam logic [DEF_NPAT*DEF_LEN_W-1:0]  DEF_LEN    = 16'h4333;
    localparam logic [DEF_NPAT-1:0]            DEF_ANCHOR = 4'b1000;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_BODY   = 2'd1,
        S_REPORT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_char_decode.sv
`timescale 1ns/1ps
module scan_char_decode #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES*8-1:0]        data,
    output logic [LANES-1:0][255:0]   lines
);
    for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
        always_comb begin
            lines[gj] = '0;
            lines[gj][data[gj*8 +: 8]] = 1'b1;
        end
    end
endmodule

// File: rtl/scan_frame_ctrl.sv
`timescale 1ns/1ps
module scan_frame_ctrl
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_eop,
    output logic accept,
    output logic start,
    output logic report
);
    scan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && in_sop) state_d = in_eop ? S_REPORT : S_BODY;
            end
            S_BODY: begin
                if (in_valid && in_eop) state_d = S_REPORT;
            end
            S_REPORT: begin
                if (in_valid && in_sop) state_d = in_eop ? S_REPORT : S_BODY;
                else                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept = in_valid && (in_sop || (state_q == S_BODY));
        start  = accept && in_sop;
        report = (state_q == S_REPORT);
    end

    // R6
    report_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_eop) |=> report);
    // R6
    report_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report |-> $past(accept && in_eop));
endmodule

// File: rtl/scan_chain.sv
`timescale 1ns/1ps
module scan_chain #(
    parameter int unsigned          LANES  = 4,
    parameter int unsigned          MAXLEN = 4,
    parameter int unsigned          LEN    = 3,
    parameter logic [MAXLEN*8-1:0]  CHARS  = '0,
    parameter logic [MAXLEN-1:0]    WILD   = '0,
    parameter bit                   ANCHOR = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0][255:0]   lines,
    input  logic [LANES-1:0]          keep,
    input  logic                      accept,
    input  logic                      start,
    output logic                      hit_sticky
);
    logic [LANES-1:0][MAXLEN-1:0] ok;
    logic [MAXLEN-1:0]            carry_q;
    logic [MAXLEN-1:0]            run;
    logic [MAXLEN-1:0]            nxt;
    logic                         seed;
    logic                         hit_now;
    logic                         sticky_q;

    for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
        for (genvar gk = 0; gk < MAXLEN; gk++) begin : g_pos
            if (WILD[gk]) begin : g_wild
                assign ok[gj][gk] = 1'b1;
            end else begin : g_char
                assign ok[gj][gk] = lines[gj][CHARS[gk*8 +: 8]];
            end
        end
    end

    always_comb begin
        hit_now = 1'b0;
        run     = start ? '0 : carry_q;
        nxt     = '0;
        seed    = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            for (int k = 0; k < MAXLEN; k++) begin
                if (k == 0) seed = ANCHOR ? (start && (j == 0)) : 1'b1;
                else        seed = run[k-1];
                nxt[k] = (k < LEN) && seed && ok[j][k] && keep[j] && accept;
            end
            run     = nxt;
            hit_now = hit_now | run[LEN-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q  <= '0;
            sticky_q <= 1'b0;
        end else if (accept) begin
            carry_q  <= run;
            sticky_q <= (sticky_q && !start) || hit_now;
        end
    end

    assign hit_sticky = sticky_q;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !start) |=> sticky_q);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(sticky_q) && $stable(carry_q)));
endmodule

// File: rtl/pattern_scan.sv
`timescale 1ns/1ps
module pattern_scan
    import scan_pkg::*;
#(
    parameter int unsigned                 LANES      = 4,
    parameter int unsigned                 NPAT       = DEF_NPAT,
    parameter int unsigned                 MAXLEN     = DEF_MAXLEN,
    parameter int unsigned                 LEN_W      = DEF_LEN_W,
    parameter logic [NPAT*MAXLEN*8-1:0]    PAT_CHARS  = DEF_CHARS,
    parameter logic [NPAT*MAXLEN-1:0]      PAT_WILD   = DEF_WILD,
    parameter logic [NPAT*LEN_W-1:0]       PAT_LEN    = DEF_LEN,
    parameter logic [NPAT-1:0]             PAT_ANCHOR = DEF_ANCHOR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic [LANES*8-1:0]   in_data,
    input  logic [LANES-1:0]     in_keep,
    output logic                 match_valid,
    output logic [NPAT-1:0]      match_bits
);
    localparam int unsigned CW = MAXLEN * 8;

    logic                       accept;
    logic                       start;
    logic [LANES-1:0][255:0]    lines;

    scan_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .accept   (accept),
        .start    (start),
        .report   (match_valid)
    );

    scan_char_decode #(.LANES(LANES)) u_dec (
        .data  (in_data),
        .lines (lines)
    );

    for (genvar gp = 0; gp < NPAT; gp++) begin : g_pat
        scan_chain #(
            .LANES  (LANES),
            .MAXLEN (MAXLEN),
            .LEN    (int'(PAT_LEN[gp*LEN_W +: LEN_W])),
            .CHARS  (PAT_CHARS[gp*CW +: CW]),
            .WILD   (PAT_WILD[gp*MAXLEN +: MAXLEN]),
            .ANCHOR (PAT_ANCHOR[gp])
        ) u_chain (
            .clk        (clk),
            .rst_n      (rst_n),
            .lines      (lines),
            .keep       (in_keep),
            .accept     (accept),
            .start      (start),
            .hit_sticky (match_bits[gp])
        );
    end
endmodule

// File: tb/tb_pattern_scan.sv
`timescale 1ns/1ps
module tb_pattern_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_keep = '0;
    logic        match_valid;
    logic [3:0]  match_bits;

    int checks = 0;
    int errors = 0;
    logic [7:0] pkt [0:67];
    string pats [4] = '{"abc", "dcc", "x?z", "HEAD"};
    bit    anch [4] = '{1'b0, 1'b0, 1'b0, 1'b1};
    logic [7:0] alpha [10] = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h78,
                               8'h7a, 8'h48, 8'h45, 8'h41, 8'h79};

    always #10 clk = ~clk;

    pattern_scan dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_keep(in_keep),
        .match_valid(match_valid), .match_bits(match_bits)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_match(input int n);
        logic [3:0] r = '0;
        for (int p = 0; p < 4; p++) begin
            int len = pats[p].len();
            for (int s = 0; s + len <= n; s++) begin
                bit hit = 1'b1;
                if (anch[p] && s != 0) continue;
                for (int k = 0; k < len; k++) begin
                    logic [7:0] c = pats[p][k];
                    if (c != 8'h3f && pkt[s+k] != c) hit = 1'b0;
                end
                if (hit) r[p] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic int load(input string s);
        for (int i = 0; i < s.len(); i++) pkt[i] = s[i];
        return s.len();
    endfunction

    task automatic drive_word(input int off, input logic [3:0] keep, input bit sop, input bit eop);
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = sop;
        in_eop   = eop;
        in_keep  = keep;
        in_data  = {pkt[off+3], pkt[off+2], pkt[off+1], pkt[off]};
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_pkt(input int n, input string req);
        int nw = (n + 3) / 4;
        logic [3:0] exp = ref_match(n);
        for (int w = 0; w < nw; w++) begin
            logic [3:0] kp = '0;
            for (int j = 0; j < 4; j++) if (w*4 + j < n) kp[j] = 1'b1;
            drive_word(w*4, kp, w == 0, w == nw - 1);
        end
        idle_cycle();
        check(match_valid === 1'b1, "R6", match_valid, 1);
        check(match_bits === exp, req, match_bits, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] held;
        void'($urandom(32'd1234));
        for (int i = 0; i < 68; i++) pkt[i] = 8'h79;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(match_valid === 1'b0, "R1", match_valid, 0);
        check(match_bits === 4'b0, "R1", match_bits, 0);
        rst_n = 1'b1;
        @(negedge clk);

        n = load("abcy");          send_pkt(n, "R3");
        n = load("yabc");          send_pkt(n, "R3");
        n = load("yyyyyyab" );     n = load("yyyyyyabcyyy"); send_pkt(n, "R2");
        n = load("yyabcyy");       send_pkt(n, "R2");
        n = load("yyyadccy");      send_pkt(n, "R2");
        n = load("yx#zyy");        send_pkt(n, "R4");
        n = load("yyyx");  pkt[4] = 8'h00; pkt[5] = 8'h7a; n = 6; send_pkt(n, "R4");
        n = load("HEADyy");        send_pkt(n, "R5");
        n = load("yHEAD");         send_pkt(n, "R5");
        n = load("yyyyHEAD");      send_pkt(n, "R5");
        n = load("abcdccxAzHEAD"); send_pkt(n, "R10");
        n = load("HEADabcxbz");    send_pkt(n, "R10");

        // R8 pattern would finish in a masked lane
        n = load("zzzzzabc"); n = 7; send_pkt(n, "R8");
        n = load("yyyyabcy"); n = 5; send_pkt(n, "R8");

        // R6 result held after the pulse; R9 ignored words
        n = load("abcxyz"); send_pkt(n, "R6");
        held = match_bits;
        @(negedge clk);
        check(match_valid === 1'b0, "R6", match_valid, 0);
        check(match_bits === held, "R6", match_bits, held);
        n = load("HEADdcc");
        drive_word(0, 4'hf, 1'b0, 1'b0);
        drive_word(4, 4'h7, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
        @(negedge clk);
        check(match_valid === 1'b0, "R9", match_valid, 0);
        check(match_bits === held, "R9", match_bits, held);
        idle_cycle();

        // R7 prefix from a finished packet does not carry over
        n = load("yyab"); send_pkt(n, "R7");
        n = load("cyy");  send_pkt(n, "R7");
        // R7 start word in mid-packet restarts
        n = load("zzab");
        drive_word(0, 4'hf, 1'b1, 1'b0);
        n = load("cdcc");
        drive_word(0, 4'hf, 1'b1, 1'b1);
        idle_cycle();
        check(match_valid === 1'b1, "R7", match_valid, 1);
        check(match_bits === 4'b0010, "R7", match_bits, 4'b0010);

        // random packets, back-to-back and with gaps / junk words
        for (int t = 0; t < 300; t++) begin
            int len = 1 + int'($urandom_range(39));
            int gap = int'($urandom_range(2));
            for (int i = 0; i < 44; i++) pkt[i] = alpha[$urandom_range(9)];
            if ($urandom_range(3) == 0) begin
                pkt[0] = 8'h48; pkt[1] = 8'h45; pkt[2] = 8'h41; pkt[3] = 8'h44;
            end
            send_pkt(len, "R10");
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = $urandom_range(1); in_sop = 1'b0; in_eop = $urandom_range(1);
                in_data = $urandom; in_keep = 4'hf;
            end
        end
        idle_cycle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule